// File: doc/BRIEF.md
# Configurable Single-Port Block RAM

This block is a synchronous RAM with one address port shared by reads and writes. It is built on a storage array of roughly 9 kbit. Its logical shape is picked at elaboration from a short list of depth-by-width pairs, and any other pair stops elaboration. The parity-friendly widths 9, 18 and 36 are on the list. For each access the block takes one address, which it either captures from the input or holds from the previous access. The block writes the word, or only the enabled byte lanes, and it can return a read result in the same cycle.

When a read and a write fall on the same edge, a parameter decides what comes back: either the word just formed by the write, or the contents that were there before. When read enable is low, the read result is frozen. An optional output register sits on its own clock with its own enable. An asynchronous clear zeroes whichever register drives the output pins, and it never touches the stored words. An input clock enable can make an input edge have no effect at all.

Top module: `ram_sp_cfg`

## Requirements
- R1: Only the shapes DEPTH x WIDTH = 8192x1, 4096x2, 2048x4, 1024x8, 1024x9, 512x16, 512x18, 256x32 and 256x36 elaborate. Any other pair raises an elaboration error. Every bit of the chosen width is stored and returned.
- R2: With `OUT_REG`=0, a read captured on an `in_clk` edge (`in_ce`=1, `rd_en`=1) shows the word at the effective address on `rd_data` right after that edge. With `OUT_REG`=1, the word appears after the next `out_clk` edge on which `out_ce` is 1.
- R3: On an edge where `rd_en` is 0, the read result keeps its value from the most recent read, and this includes edges that write.
- R4: With `POLICY`=RDW_NEW_DATA, a read and a write on the same edge return the merged word: the enabled lanes take the new data and the disabled lanes keep their old bits.
- R5: With `POLICY`=RDW_OLD_DATA, a read and a write on the same edge return the contents of the address as they were before that write.
- R6: For WIDTH >= 16 there is one `lane_en` bit per lane. Lane i covers bits [i*L +: L], where L is 9 when WIDTH is a multiple of 9 and 8 otherwise. A write leaves the bits of a disabled lane unchanged. For WIDTH < 16, `lane_en` is one bit, it is ignored, and the whole word is written.
- R7: When `addr_hold` is 1, the access uses the address captured at the previous enabled edge and ignores `addr_in`. When `addr_hold` is 0, `addr_in` is used and captured.
- R8: On an `in_clk` edge with `in_ce`=0, nothing is written, the captured address does not change and the read result does not change.
- R9: With `OUT_REG`=1, an `out_clk` edge with `out_ce`=0 leaves `rd_data` unchanged.
- R10: Raising `out_clr` drives `rd_data` to zero at once, without waiting for a clock edge. It clears the output register when `OUT_REG`=1 and the read register otherwise. Stored words are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock for address capture, writes and reads |
| in_ce | input | 1 | Enable for each `in_clk` edge |
| addr_in | input | log2(DEPTH) | Word address |
| addr_hold | input | 1 | Reuse the previously captured address |
| wr_en | input | 1 | Write the word at the effective address |
| rd_en | input | 1 | Update the read result |
| wr_data | input | WIDTH | Write data |
| lane_en | input | WIDTH/L for WIDTH>=16, else 1 | Per-lane write enables |
| out_clk | input | 1 | Clock of the optional output register |
| out_ce | input | 1 | Enable of the output register |
| out_clr | input | 1 | Asynchronous clear of the register that drives `rd_data` |
| rd_data | output | WIDTH | Read data |

## Verification
A write and a read can land on the same `in_clk` edge at one address. The bench provokes this by sweeping addresses with both enables high and with all four lane-enable patterns. Two instances receive the same stimulus: one uses the new-data policy with a direct output, and the other uses the old-data policy behind the output register. Each instance is judged against a reference array, which yields the merged word and the prior word respectively. A clear pulse placed in the middle of a cycle, between edges, is judged by an immediate read of zero on both instances, followed by a read-back showing that the stored contents survived.

// File: rtl/ram_sp_pkg.sv
package ram_sp_pkg;

    typedef enum logic {
        RDW_NEW_DATA = 1'b0,
        RDW_OLD_DATA = 1'b1
    } rdw_e;

    function automatic bit shape_ok(int depth, int width);
        case (width)
            1:       return depth == 8192;
            2:       return depth == 4096;
            4:       return depth == 2048;
            8, 9:    return depth == 1024;
            16, 18:  return depth == 512;
            32, 36:  return depth == 256;
            default: return 1'b0;
        endcase
    endfunction

    function automatic int lane_bits(int width);
        return (width % 9 == 0) ? 9 : 8;
    endfunction

    function automatic int lanes(int width);
        return (width >= 16) ? width / lane_bits(width) : 1;
    endfunction

    function automatic int addr_w(int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/ram_sp_cfg_addr.sv
module ram_sp_cfg_addr #(
    parameter int AW = 9
) (
    input  logic          in_clk,
    input  logic          in_ce,
    input  logic          hold,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] addr_eff,
    output logic [AW-1:0] addr_q
);
    // address used this edge: the held one while stalled
    assign addr_eff = hold ? addr_q : addr_in;

    always_ff @(posedge in_clk) begin
        if (in_ce) begin
            addr_q <= addr_eff;
        end
    end
endmodule

// File: rtl/ram_sp_cfg_array.sv
module ram_sp_cfg_array
    import ram_sp_pkg::*;
#(
    parameter int   DEPTH     = 512,
    parameter int   WIDTH     = 18,
    parameter int   AW        = 9,
    parameter int   NL        = 2,
    parameter int   LSPAN     = 9,
    parameter bit   CLR_HERE  = 1'b1,
    parameter rdw_e POLICY    = RDW_NEW_DATA
) (
    input  logic             in_clk,
    input  logic             in_ce,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [NL-1:0]    lane_en,
    input  logic             clr,
    output logic [WIDTH-1:0] rd_q
);
    typedef struct packed {
        logic             wr;
        logic             rd;
        logic [AW-1:0]    addr;
        logic [NL-1:0]    mask;
        logic [WIDTH-1:0] data;
    } req_t;

    logic [WIDTH-1:0] mem [DEPTH];
    req_t             req;
    logic [WIDTH-1:0] cur;
    logic [WIDTH-1:0] merged;
    logic [WIDTH-1:0] rd_next;

    assign req.wr   = in_ce & wr_en;
    assign req.rd   = in_ce & rd_en;
    assign req.addr = addr;
    assign req.mask = (WIDTH >= 16) ? lane_en : {NL{1'b1}};
    assign req.data = wr_data;

    assign cur = mem[req.addr];

    always_comb begin
        merged = cur;
        for (int i = 0; i < NL; i++) begin
            if (req.mask[i]) begin
                merged[i*LSPAN +: LSPAN] = req.data[i*LSPAN +: LSPAN];
            end
        end
    end

    // read-during-write policy picks what a simultaneous read returns
    assign rd_next = (POLICY == RDW_NEW_DATA && req.wr) ? merged : cur;

    always_ff @(posedge in_clk) begin
        if (req.wr) begin
            mem[req.addr] <= merged;
        end
    end

    generate
        if (CLR_HERE) begin : g_clr
            always_ff @(posedge in_clk or posedge clr) begin
                if (clr) begin
                    rd_q <= '0;
                end else if (req.rd) begin
                    rd_q <= rd_next;
                end
            end
        end else begin : g_noclr
            logic unused_clr;
            assign unused_clr = clr;
            always_ff @(posedge in_clk) begin
                if (req.rd) begin
                    rd_q <= rd_next;
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ram_sp_cfg_oreg.sv
module ram_sp_cfg_oreg #(
    parameter int WIDTH = 18
) (
    input  logic             out_clk,
    input  logic             out_ce,
    input  logic             clr,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    always_ff @(posedge out_clk or posedge clr) begin
        if (clr) begin
            q <= '0;
        end else if (out_ce) begin
            q <= d;
        end
    end
endmodule

// File: rtl/ram_sp_cfg.sv
module ram_sp_cfg
    import ram_sp_pkg::*;
#(
    parameter int   DEPTH   = 512,
    parameter int   WIDTH   = 18,
    parameter bit   OUT_REG = 1'b0,
    parameter rdw_e POLICY  = RDW_NEW_DATA
) (
    input  logic                     in_clk,
    input  logic                     in_ce,
    input  logic [addr_w(DEPTH)-1:0] addr_in,
    input  logic                     addr_hold,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [WIDTH-1:0]         wr_data,
    input  logic [lanes(WIDTH)-1:0]  lane_en,
    input  logic                     out_clk,
    input  logic                     out_ce,
    input  logic                     out_clr,
    output logic [WIDTH-1:0]         rd_data
);
    localparam int AW    = addr_w(DEPTH);
    localparam int NL    = lanes(WIDTH);
    localparam int LSPAN = WIDTH / NL;

    // R1: reject shapes outside the supported menu
    generate
        if (!shape_ok(DEPTH, WIDTH)) begin : g_bad_shape
            $error("ram_sp_cfg: unsupported shape %0d x %0d", DEPTH, WIDTH);
        end
    endgenerate

    logic [AW-1:0]    addr_eff;
    logic [AW-1:0]    addr_q;
    logic [WIDTH-1:0] arr_q;

    ram_sp_cfg_addr #(.AW(AW)) u_addr (
        .in_clk   (in_clk),
        .in_ce    (in_ce),
        .hold     (addr_hold),
        .addr_in  (addr_in),
        .addr_eff (addr_eff),
        .addr_q   (addr_q)
    );

    ram_sp_cfg_array #(
        .DEPTH    (DEPTH),
        .WIDTH    (WIDTH),
        .AW       (AW),
        .NL       (NL),
        .LSPAN    (LSPAN),
        .CLR_HERE (!OUT_REG),
        .POLICY   (POLICY)
    ) u_array (
        .in_clk  (in_clk),
        .in_ce   (in_ce),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr_eff),
        .wr_data (wr_data),
        .lane_en (lane_en),
        .clr     (out_clr),
        .rd_q    (arr_q)
    );

    generate
        if (OUT_REG) begin : g_oreg
            ram_sp_cfg_oreg #(.WIDTH(WIDTH)) u_oreg (
                .out_clk (out_clk),
                .out_ce  (out_ce),
                .clr     (out_clr),
                .d       (arr_q),
                .q       (rd_data)
            );
        end else begin : g_direct
            logic unused_out;
            assign unused_out = out_clk ^ out_ce;
            assign rd_data    = arr_q;
        end
    endgenerate
endmodule

module ram_sp_cfg_chk
    import ram_sp_pkg::*;
#(
    parameter int   WIDTH   = 18,
    parameter int   AW      = 9,
    parameter int   NL      = 2,
    parameter bit   OUT_REG = 1'b0,
    parameter rdw_e POLICY  = RDW_NEW_DATA
) (
    input logic             in_clk,
    input logic             in_ce,
    input logic [AW-1:0]    addr_in,
    input logic             addr_hold,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] wr_data,
    input logic [NL-1:0]    lane_en,
    input logic             out_clk,
    input logic             out_ce,
    input logic             out_clr,
    input logic [AW-1:0]    addr_q,
    input logic [WIDTH-1:0] arr_q,
    input logic [WIDTH-1:0] rd_data
);
    logic seen_in = 1'b0;
    always @(posedge in_clk) seen_in <= 1'b1;

    a_r3_hold_without_read: assert property (@(posedge in_clk) disable iff (out_clr)
        (seen_in && in_ce && !rd_en) |=> $stable(arr_q));

    a_r7_stall_keeps_addr: assert property (@(posedge in_clk) disable iff (out_clr)
        (seen_in && in_ce && addr_hold) |=> addr_q == $past(addr_q));

    a_r7_take_new_addr: assert property (@(posedge in_clk) disable iff (out_clr)
        (seen_in && in_ce && !addr_hold) |=> addr_q == $past(addr_in));

    a_r8_idle_edge: assert property (@(posedge in_clk) disable iff (out_clr)
        (seen_in && !in_ce) |=> ($stable(addr_q) && $stable(arr_q)));

    a_r10_cleared: assert property (@(negedge out_clr) rd_data == '0);

    generate
        if (POLICY == RDW_NEW_DATA) begin : g_new
            a_r4_new_word: assert property (@(posedge in_clk) disable iff (out_clr)
                (seen_in && in_ce && rd_en && wr_en && (&lane_en)) |=> arr_q == $past(wr_data));
        end
        if (OUT_REG) begin : g_oreg
            logic seen_out = 1'b0;
            always @(posedge out_clk) seen_out <= 1'b1;
            a_r9_out_hold: assert property (@(posedge out_clk) disable iff (out_clr)
                (seen_out && !out_ce) |=> $stable(rd_data));
        end else begin : g_nooreg
            logic unused_chk;
            assign unused_chk = out_clk ^ out_ce;
        end
    endgenerate
endmodule

bind ram_sp_cfg ram_sp_cfg_chk #(
    .WIDTH   (WIDTH),
    .AW      (AW),
    .NL      (NL),
    .OUT_REG (OUT_REG),
    .POLICY  (POLICY)
) u_chk (
    .in_clk    (in_clk),
    .in_ce     (in_ce),
    .addr_in   (addr_in),
    .addr_hold (addr_hold),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .wr_data   (wr_data),
    .lane_en   (lane_en),
    .out_clk   (out_clk),
    .out_ce    (out_ce),
    .out_clr   (out_clr),
    .addr_q    (addr_q),
    .arr_q     (arr_q),
    .rd_data   (rd_data)
);

// File: tb/sim_ram_sp_cfg.sv
`timescale 1ns/1ps
module sim_ram_sp_cfg;
    import ram_sp_pkg::*;

    logic        clk = 1'b0;
    logic        in_ce, addr_hold, wr_en, rd_en, out_ce, out_clr;
    logic [8:0]  addr_in;
    logic [17:0] wr_data;
    logic [1:0]  lane_en;
    logic [17:0] q0, q1;

    always #4 clk = ~clk;

    // u0: new-data policy, direct output
    ram_sp_cfg #(.DEPTH(512), .WIDTH(18), .OUT_REG(1'b0), .POLICY(RDW_NEW_DATA)) u0 (
        .in_clk(clk), .in_ce(in_ce), .addr_in(addr_in), .addr_hold(addr_hold),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .lane_en(lane_en),
        .out_clk(clk), .out_ce(out_ce), .out_clr(out_clr), .rd_data(q0)
    );

    // u1: old-data policy, registered output
    ram_sp_cfg #(.DEPTH(512), .WIDTH(18), .OUT_REG(1'b1), .POLICY(RDW_OLD_DATA)) u1 (
        .in_clk(clk), .in_ce(in_ce), .addr_in(addr_in), .addr_hold(addr_hold),
        .wr_en(wr_en), .rd_en(rd_en), .wr_data(wr_data), .lane_en(lane_en),
        .out_clk(clk), .out_ce(out_ce), .out_clr(out_clr), .rd_data(q1)
    );

    int n_run  = 0;
    int n_fail = 0;

    logic [17:0] ref_mem [512];
    logic [17:0] h0, h1, o1;
    bit          v1, vo1;
    logic [8:0]  last;
    string       ptag, tg1;

    function automatic logic [17:0] pat(int a);
        return 18'((a * 1237 + 91) & 18'h3FFFF);
    endfunction

    task automatic check(string tg, logic [17:0] act, logic [17:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tg, act, exp);
        end
    endtask

    // drive one access, advance one edge, compare both instances
    task automatic step(bit w, bit r, int a, logic [17:0] d, logic [1:0] le,
                        bit hold, bit ce, string tg);
        logic [8:0]  eff;
        logic [17:0] cur, mg;
        wr_en = w; rd_en = r; addr_in = 9'(a); wr_data = d;
        lane_en = le; addr_hold = hold; in_ce = ce;
        if (out_ce) begin
            o1 = h1; vo1 = v1; tg1 = ptag;
        end else begin
            tg1 = "R9";
        end
        if (ce) begin
            eff = hold ? last : 9'(a);
            cur = ref_mem[eff];
            mg  = cur;
            if (le[0]) mg[8:0]  = d[8:0];
            if (le[1]) mg[17:9] = d[17:9];
            if (r) begin
                h0 = w ? mg : cur;
                h1 = cur;
                v1 = 1'b1;
                ptag = w ? "R5" : tg;
            end
            if (w) ref_mem[eff] = mg;
            last = eff;
        end
        @(posedge clk);
        @(negedge clk);
        check(tg, q0, h0);
        if (vo1) check(tg1, q1, o1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        in_ce = 0; wr_en = 0; rd_en = 0; addr_in = 0; addr_hold = 0;
        wr_data = 0; lane_en = 0; out_ce = 0; out_clr = 1;
        h0 = 0; h1 = 0; o1 = 0; v1 = 0; vo1 = 1; last = 0;
        ptag = "R2"; tg1 = "R2";
        @(negedge clk);
        out_clr = 0;
        #1;
        check("R10", q0, 18'h0);
        check("R10", q1, 18'h0);

        // fill with read disabled: outputs hold (R3), u1 out reg gated off (R9)
        for (int a = 0; a < 512; a++) step(1, 0, a, pat(a), 2'b11, 0, 1, "R3");

        // read sweep
        out_ce = 1;
        for (int a = 0; a < 512; a++) step(0, 1, a, 18'h0, 2'b00, 0, 1, "R2");

        // full-width patterns
        step(1, 0, 5, 18'h3FFFF, 2'b11, 0, 1, "R3");
        step(0, 1, 5, 18'h0, 2'b00, 0, 1, "R1");
        step(1, 0, 5, 18'h20001, 2'b11, 0, 1, "R3");
        step(0, 1, 5, 18'h0, 2'b00, 0, 1, "R1");

        // read-during-write with every lane mask
        for (int i = 0; i < 64; i++)
            step(1, 1, (i * 7 + 3) % 512, pat(i + 1000) ^ 18'h2AAAA, 2'(i % 4), 0, 1, "R4");
        for (int i = 0; i < 64; i++)
            step(0, 1, (i * 7 + 3) % 512, 18'h0, 2'b00, 0, 1, "R6");

        // address stall
        step(0, 1, 10, 18'h0, 2'b00, 0, 1, "R7");
        step(1, 1, 200, 18'h15A5A, 2'b11, 1, 1, "R7");
        step(0, 1, 200, 18'h0, 2'b00, 0, 1, "R7");
        step(0, 1, 10, 18'h0, 2'b00, 0, 1, "R7");

        // input clock enable low
        step(1, 1, 20, 18'h0F0F0, 2'b11, 0, 0, "R8");
        step(0, 1, 99, 18'h0, 2'b00, 1, 1, "R8");
        step(0, 1, 20, 18'h0, 2'b00, 0, 1, "R8");

        // output enable low
        out_ce = 0;
        for (int i = 0; i < 3; i++) step(0, 1, 30 + i, 18'h0, 2'b00, 0, 1, "R9");
        out_ce = 1;
        step(0, 1, 40, 18'h0, 2'b00, 0, 1, "R2");
        step(0, 1, 41, 18'h0, 2'b00, 0, 1, "R2");

        // asynchronous clear between edges
        #1 out_clr = 1;
        #1 out_clr = 0;
        #1;
        check("R10", q0, 18'h0);
        check("R10", q1, 18'h0);
        h0 = 0; o1 = 0; vo1 = 1;
        for (int a = 0; a < 16; a++) step(0, 1, a, 18'h0, 2'b00, 0, 1, "R10");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule